// File: doc/BRIEF.md
# Peripheral I/O Address Decoder

This block sits beside an input/output request path and turns a 16-bit addressing word into a single target choice plus a three-way response code. The word carries a five-bit buffered-channel code in its top bits, a four-bit equipment number below that, and a seven-bit command field at the bottom. A zero channel code sends the request to an ordinary controller named by the equipment number. A non-zero channel code sends it to one of several buffered data channels, each of which answers to a group of consecutive codes.

One equipment number is shared by several small devices. For that number, three bits of the command field act as a station code that picks the device. Per-equipment settings are kept in a small table loaded through a write port: present, protect-capable, marked protected, direct-only and a read mask. Requests to absent equipment, to unknown station or channel codes, or through a channel to a direct-only device receive an internal reject. In protect mode, an unprivileged request to a protect-capable device that is not marked protected receives a reject, unless it is a status read.

A request is presented with `req_valid` for one cycle. It is accepted in that cycle, because the block never applies back-pressure. The result appears one clock later with a one-cycle `rsp_valid` pulse. Status and select then hold their values until the next request. Requests may be issued on consecutive cycles.

Top module: `io_addr_decoder`

## Requirements
- R1: With the channel code (bits 15..11) zero and the equipment number (bits 10..7) naming a present equipment other than the shared one, and with no protect rejection, the response is reply (code 0) and `rsp_sel` has only the bit equal to the equipment number set.
- R2: With the channel code zero and a non-shared equipment number whose table entry is not present, the response is internal reject (code 2) with `rsp_sel` all zero.
- R3: Equipment number 1 is shared and always counts as present. Its station code (bits 6..4) of 001, 010 or 100 selects `rsp_sel` bit 16, 17 or 18 respectively. Any other station code gives internal reject, whatever the channel code.
- R4: A channel code W in 1..12 addresses channel (W-1)/4 and sets only `rsp_sel` bit 19+(W-1)/4 with status reply. The protect rule does not apply to channel accesses.
- R5: A channel code in 13..31 gives internal reject with `rsp_sel` zero.
- R6: With a non-zero channel code, an addressed equipment that is present and marked direct-only gives internal reject. This check takes effect before the channel code is decoded.
- R7: With the channel code zero and a present target, the response is reject (code 1) with `rsp_sel` zero when all of these hold: `prot_mode`=1, `req_priv`=0, and the equipment's entry is protect-capable and not marked protected. For the shared equipment, the entry of equipment 1 is used.
- R8: An input request (`req_is_out`=0) whose command bits 6..0 ANDed with the equipment's read mask equal 1 is a status read and is never protect-rejected.
- R9: Each `req_valid` cycle produces `rsp_valid` high for exactly the next cycle, carrying that request's result. Without a request, `rsp_valid` is low and `rsp_status` and `rsp_sel` keep their values.
- R10: After reset, `rsp_valid`, `rsp_status` and `rsp_sel` are zero and every table entry is cleared, so it is not present.
- R11: A write with `cfg_we`=1 stores the settings at `cfg_idx`. A request in the same cycle still sees the old entry, and later requests see the new one.
- R12: `rsp_status` is never 3. `rsp_sel` is one-hot when the status is reply and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_addr | input | 16 | Addressing word: channel code, equipment number, command |
| req_is_out | input | 1 | 1 for an output request, 0 for input |
| req_priv | input | 1 | Request comes from a protected (privileged) instruction |
| prot_mode | input | 1 | Protect mode active |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | 4 | Equipment number to write |
| cfg_present | input | 1 | Equipment is fitted and enabled |
| cfg_prot_cap | input | 1 | Equipment is subject to the protect rule |
| cfg_prot_marked | input | 1 | Equipment is marked protected |
| cfg_direct_only | input | 1 | Equipment may not be reached through a channel |
| cfg_rd_mask | input | 7 | Command mask used to recognise a status read |
| rsp_valid | output | 1 | Result pulse, one cycle after the request |
| rsp_status | output | 2 | 0 reply, 1 reject, 2 internal reject |
| rsp_sel | output | 22 | One-hot target: 0..15 equipment, 16..18 stations, 19..21 channels |

## Verification
A stale or wrong table entry shows up on the next request aimed at that equipment number. It appears in the following cycle as a wrong status: an internal reject where a reply was due, or a reject that should have been lifted. A fault in the channel or station decoders moves the select bit or changes the status for whole groups of codes. The bench therefore sweeps every channel code, equipment number and station code under several table settings. A fault in the output register breaks the one-cycle pulse or the hold between requests, and this is seen on the first idle cycle.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

  typedef enum logic [1:0] {
    RSP_REPLY  = 2'd0,
    RSP_REJECT = 2'd1,
    RSP_INTREJ = 2'd2
  } rsp_e;

  typedef struct packed {
    logic       present;
    logic       prot_cap;
    logic       prot_marked;
    logic       direct_only;
    logic [6:0] rd_mask;
  } eq_cfg_t;

  // Fixed layout of the addressing word; neighbours decode these fields.
  localparam int ADDR_W   = 16;
  localparam int CHAN_LSB = 11;
  localparam int CHAN_W   = 5;
  localparam int EQ_LSB   = 7;
  localparam int EQ_W     = 4;
  localparam int STA_LSB  = 4;
  localparam int STA_W    = 3;
  localparam int CMD_W    = 7;
  localparam int NUM_EQ   = 1 << EQ_W;

endpackage

// File: rtl/io_cfg_table.sv
module io_cfg_table
  import io_dec_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  eq_cfg_t          wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output eq_cfg_t          rd_data
);

  eq_cfg_t tbl [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_data;
    end
  end

  assign rd_data = tbl[rd_idx];

endmodule

// File: rtl/io_chan_decode.sv
module io_chan_decode #(
  parameter int CODE_W         = 5,
  parameter int NUM_CHAN       = 3,
  parameter int CODES_PER_CHAN = 4
) (
  input  logic [CODE_W-1:0]   code,
  output logic [NUM_CHAN-1:0] hit,
  output logic                known
);

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    localparam int LO = c * CODES_PER_CHAN + 1;
    localparam int HI = (c + 1) * CODES_PER_CHAN;
    assign hit[c] = (int'(code) >= LO) && (int'(code) <= HI);
  end

  assign known = |hit;

endmodule

// File: rtl/io_station_decode.sv
module io_station_decode #(
  parameter int STA_W   = 3,
  parameter int NUM_STA = 3
) (
  input  logic [STA_W-1:0]   code,
  output logic [NUM_STA-1:0] hit,
  output logic               known
);

  // Station s answers only to the code with bit s alone set.
  for (genvar s = 0; s < NUM_STA; s++) begin : g_sta
    localparam logic [STA_W-1:0] MATCH = STA_W'(1) << s;
    assign hit[s] = (code == MATCH);
  end

  assign known = |hit;

endmodule

// File: rtl/io_addr_decoder.sv
module io_addr_decoder
  import io_dec_pkg::*;
#(
  parameter int NUM_CHAN       = 3,
  parameter int CODES_PER_CHAN = 4,
  parameter int NUM_STA        = 3,
  parameter int SHARED_EQ      = 1,
  localparam int SEL_W         = NUM_EQ + NUM_STA + NUM_CHAN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [15:0]      req_addr,
  input  logic             req_is_out,
  input  logic             req_priv,
  input  logic             prot_mode,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_idx,
  input  logic             cfg_present,
  input  logic             cfg_prot_cap,
  input  logic             cfg_prot_marked,
  input  logic             cfg_direct_only,
  input  logic [6:0]       cfg_rd_mask,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [SEL_W-1:0] rsp_sel
);

  localparam int STA_BASE  = NUM_EQ;
  localparam int CHAN_BASE = NUM_EQ + NUM_STA;

  logic [CHAN_W-1:0] f_chan;
  logic [EQ_W-1:0]   f_eq;
  logic [STA_W-1:0]  f_sta;
  logic [CMD_W-1:0]  f_cmd;

  assign f_chan = req_addr[CHAN_LSB +: CHAN_W];
  assign f_eq   = req_addr[EQ_LSB +: EQ_W];
  assign f_sta  = req_addr[STA_LSB +: STA_W];
  assign f_cmd  = req_addr[CMD_W-1:0];

  eq_cfg_t wr_cfg, eq_cfg;
  assign wr_cfg = '{present: cfg_present, prot_cap: cfg_prot_cap,
                    prot_marked: cfg_prot_marked, direct_only: cfg_direct_only,
                    rd_mask: cfg_rd_mask};

  io_cfg_table #(.ENTRIES(NUM_EQ)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (wr_cfg),
    .rd_idx  (f_eq),
    .rd_data (eq_cfg)
  );

  logic [NUM_CHAN-1:0] chan_hit;
  logic                chan_ok;
  io_chan_decode #(
    .CODE_W(CHAN_W), .NUM_CHAN(NUM_CHAN), .CODES_PER_CHAN(CODES_PER_CHAN)
  ) u_chan (
    .code  (f_chan),
    .hit   (chan_hit),
    .known (chan_ok)
  );

  logic [NUM_STA-1:0] sta_hit;
  logic               sta_ok;
  io_station_decode #(.STA_W(STA_W), .NUM_STA(NUM_STA)) u_sta (
    .code  (f_sta),
    .hit   (sta_hit),
    .known (sta_ok)
  );

  logic is_shared, present, status_read, prot_block;
  assign is_shared   = (int'(f_eq) == SHARED_EQ);
  assign present     = is_shared || eq_cfg.present;
  assign status_read = !req_is_out && ((f_cmd & eq_cfg.rd_mask) == CMD_W'(1));
  assign prot_block  = prot_mode && !req_priv && eq_cfg.prot_cap &&
                       !eq_cfg.prot_marked && !status_read;

  rsp_e             nxt_status;
  logic [SEL_W-1:0] nxt_sel;

  always_comb begin
    nxt_status = RSP_INTREJ;
    nxt_sel    = '0;
    if (is_shared && !sta_ok) begin
      nxt_status = RSP_INTREJ;
    end else if (f_chan != '0) begin
      if (present && eq_cfg.direct_only) begin
        nxt_status = RSP_INTREJ;
      end else if (chan_ok) begin
        nxt_status = RSP_REPLY;
        nxt_sel[CHAN_BASE +: NUM_CHAN] = chan_hit;
      end
    end else if (!present) begin
      nxt_status = RSP_INTREJ;
    end else if (prot_block) begin
      nxt_status = RSP_REJECT;
    end else begin
      nxt_status = RSP_REPLY;
      if (is_shared) nxt_sel[STA_BASE +: NUM_STA] = sta_hit;
      else           nxt_sel[f_eq] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      rsp_sel    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status <= nxt_status;
        rsp_sel    <= nxt_sel;
      end
    end
  end

endmodule

// File: rtl/io_addr_decoder_chk.sv
module io_addr_decoder_chk #(
  parameter int SEL_W     = 22,
  parameter int CHAN_MAX  = 12,
  parameter int NUM_STA   = 3,
  parameter int SHARED_EQ = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [15:0]      req_addr,
  input logic             rsp_valid,
  input logic [1:0]       rsp_status,
  input logic [SEL_W-1:0] rsp_sel
);

  a_r9_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_status) && $stable(rsp_sel)));

  a_r12_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'd3));

  a_r12_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_sel));

  a_r12_sel_iff_reply: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_status == 2'd0) == (rsp_sel != '0)));

  a_r5_bad_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (int'($past(req_addr[15:11])) > CHAN_MAX)) |-> (rsp_status == 2'd2));

  a_r3_bad_station: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (int'($past(req_addr[10:7])) == SHARED_EQ) &&
     !(($countones($past(req_addr[6:4])) == 1) &&
       (int'($past(req_addr[6:4])) < (1 << NUM_STA))))
    |-> (rsp_status == 2'd2));

endmodule

bind io_addr_decoder io_addr_decoder_chk #(
  .SEL_W(SEL_W), .CHAN_MAX(NUM_CHAN * CODES_PER_CHAN),
  .NUM_STA(NUM_STA), .SHARED_EQ(SHARED_EQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_sel(rsp_sel)
);

// File: tb/sim_io_addr_decoder.sv
module sim_io_addr_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int SEL_W      = 22;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [15:0]      req_addr = '0;
  logic             req_is_out = 1'b0, req_priv = 1'b0, prot_mode = 1'b0;
  logic             cfg_we = 1'b0;
  logic [3:0]       cfg_idx = '0;
  logic             cfg_present = 1'b0, cfg_prot_cap = 1'b0;
  logic             cfg_prot_marked = 1'b0, cfg_direct_only = 1'b0;
  logic [6:0]       cfg_rd_mask = '0;
  logic             rsp_valid;
  logic [1:0]       rsp_status;
  logic [SEL_W-1:0] rsp_sel;

  io_addr_decoder u0 (.*);

  int  n_vec = 0, n_bad = 0;
  bit  done = 1'b0;

  logic       m_pres [16], m_cap [16], m_mark [16], m_dir [16];
  logic [6:0] m_mask [16];

  task automatic check(input string tag, input logic [1:0] st, input logic [SEL_W-1:0] sel,
                       input logic vld, input logic [1:0] est, input logic [SEL_W-1:0] esel,
                       input logic evld);
    n_vec++;
    if (st !== est || sel !== esel || vld !== evld) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b status=%0d sel=%h, expected valid=%0b status=%0d sel=%h",
               tag, vld, st, sel, evld, est, esel);
    end
  endtask

  task automatic ref_model(input logic [15:0] a, input logic o, input logic pr, input logic pm,
                           output logic [1:0] st, output logic [SEL_W-1:0] sel,
                           output string tag);
    int w, eq, sc, tgt;
    logic pres;
    w = int'(a[15:11]); eq = int'(a[10:7]); sc = int'(a[6:4]);
    st = 2'd2; sel = '0; tag = "R2";
    if (eq == 1) begin
      if (sc == 1) tgt = 16;
      else if (sc == 2) tgt = 17;
      else if (sc == 4) tgt = 18;
      else begin tag = "R3"; return; end
    end else tgt = eq;
    pres = (eq == 1) || m_pres[eq];
    if (w != 0) begin
      if (pres && m_dir[eq]) begin tag = "R6"; return; end
      if (w > 12) begin tag = "R5"; return; end
      st = 2'd0; sel[19 + (w - 1) / 4] = 1'b1; tag = "R4"; return;
    end
    if (!pres) return;
    if (pm && !pr && m_cap[eq] && !m_mark[eq] &&
        (o || ((a[6:0] & m_mask[eq]) != 7'd1))) begin
      st = 2'd1; tag = "R7"; return;
    end
    st = 2'd0; sel[tgt] = 1'b1;
    tag = (eq == 1) ? "R3" : ((pm && !pr && m_cap[eq] && !m_mark[eq]) ? "R8" : "R1");
  endtask

  task automatic write_cfg(input int idx, input logic p, input logic c, input logic m,
                           input logic d, input logic [6:0] k);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_present = p; cfg_prot_cap = c;
    cfg_prot_marked = m; cfg_direct_only = d; cfg_rd_mask = k;
    m_pres[idx] = p; m_cap[idx] = c; m_mark[idx] = m; m_dir[idx] = d; m_mask[idx] = k;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] est;
    logic [SEL_W-1:0] esel;
    string tag;
    for (int i = 0; i < 16; i++) begin
      m_pres[i] = 0; m_cap[i] = 0; m_mark[i] = 0; m_dir[i] = 0; m_mask[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 outputs", rsp_status, rsp_sel, rsp_valid, 2'd0, '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: table cleared, equipment 5 absent
    req_valid = 1'b1; req_addr = {5'd0, 4'd5, 7'd0};
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 table clear", rsp_status, rsp_sel, rsp_valid, 2'd2, '0, 1'b1);

    // R11: write and request in the same cycle see the old entry
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd5; cfg_present = 1'b1; cfg_prot_cap = 1'b0;
    cfg_prot_marked = 1'b0; cfg_direct_only = 1'b0; cfg_rd_mask = 7'h0F;
    m_pres[5] = 1; m_mask[5] = 7'h0F;
    req_valid = 1'b1; req_addr = {5'd0, 4'd5, 7'd0};
    @(negedge clk);
    cfg_we = 1'b0;
    check("R11 old entry", rsp_status, rsp_sel, rsp_valid, 2'd2, '0, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 new entry", rsp_status, rsp_sel, rsp_valid, 2'd0, 22'(1) << 5, 1'b1);
    @(negedge clk);
    // R9: idle cycle drops valid and holds the result
    check("R9 hold", rsp_status, rsp_sel, rsp_valid, 2'd0, 22'(1) << 5, 1'b0);

    // Near-exhaustive sweep over channel code, equipment and station
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 16; i++)
        write_cfg(i, ((i * 5 + p) % 3) != 0, ((i + p) % 2) == 1,
                  (((i >> 1) + p) % 3) == 0, (i % 4) == p, (p % 2 == 0) ? 7'h0F : 7'h03);
      for (int w = 0; w < 32; w++)
        for (int eq = 0; eq < 16; eq++)
          for (int sc = 0; sc < 8; sc++) begin
            int n;
            n = (w * 16 + eq) * 8 + sc;
            @(negedge clk);
            req_valid  = 1'b1;
            req_addr   = {5'(w), 4'(eq), 3'(sc), 4'((w + eq + sc + p) % 4)};
            req_is_out = (n % 3) == 0;
            req_priv   = (n % 5) == 0;
            prot_mode  = (p != 0) || (n % 2 == 0);
            ref_model(req_addr, req_is_out, req_priv, prot_mode, est, esel, tag);
            @(negedge clk);
            req_valid = 1'b0;
            check(tag, rsp_status, rsp_sel, rsp_valid, est, esel, 1'b1);
          end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule